// File: doc/BRIEF.md
# Train control command deserializer

This block sits behind the receiver of the serial control line that carries train commands to the front-end electronics. It samples one bit per clock and runs on the same clock as the transmitter, so no clock recovery is involved. While the line is idle the block waits for a frame. The first 1 it sees marks the start of a frame and is also the first bit of a four-bit command code. Bits arrive most significant first.

Two commands, STOP and RESET, consist only of the command code. A START command is followed by 48 more bits: the train number, then the bunch pattern identifier, then a checksum byte. The block reports each valid command as a one-cycle strobe. After a valid START it presents the train number and pattern identifier on registered outputs. An unknown command code or a bad checksum produces an error strobe instead. Error strobes are tallied in a saturating counter, which the user clears with a control input.

Top module: `cmd_frame_rx`

## Requirements
- R1: While reset is active and after it is released, all strobes are low, the train number and pattern outputs are zero, and the error count is zero.
- R2: While idle, 0 bits are ignored. The first 1 bit starts a frame and is the most significant bit of the four-bit command code. All fields are sent most significant bit first.
- R3: Command code 1010 (STOP) makes `stop_o` high for exactly one cycle. That cycle is the one after the clock edge that samples the code's fourth bit.
- R4: Command code 1001 (RESET) makes `reset_o` high for exactly one cycle, with the same timing as R3.
- R5: Command code 1100 (START) is followed by 48 bits: a 32-bit train number, an 8-bit pattern identifier and an 8-bit checksum. If the checksum is valid, `start_o` pulses for one cycle in the cycle after the last bit is sampled. In that same cycle `train_id_o` and `pattern_id_o` show the new values.
- R6: A checksum is valid when it equals the XOR of the four train-number bytes and the pattern identifier byte.
- R7: On a checksum mismatch, `start_o` stays low and `csum_err_o` pulses for one cycle, with the timing of R5. `train_id_o` and `pattern_id_o` keep their previous values.
- R8: Every code other than 1100, 1010 and 1001 is an error. Because a frame begins with a 1, these are 1000, 1011, 1101, 1110 and the reserved 1111. Such a code pulses `opcode_err_o` with the timing of R3, and the very next bit is examined as idle line.
- R9: A new frame may begin in the bit immediately after the last bit of the previous frame.
- R10: Each error strobe increments `err_count_o` one cycle later. The count holds at its maximum, 2^ERR_W-1.
- R11: When `err_clr_i` is high in a cycle, `err_count_o` is zero in the next cycle. The clear takes priority over a simultaneous increment.
- R12: At most one of the five strobes is high in any cycle, and no strobe stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Serial command line, already sampled |
| err_clr_i | input | 1 | Clears the error counter |
| start_o | output | 1 | Valid START received |
| stop_o | output | 1 | STOP received |
| reset_o | output | 1 | RESET command received |
| train_id_o | output | 32 | Train number of the last valid START |
| pattern_id_o | output | 8 | Pattern identifier of the last valid START |
| csum_err_o | output | 1 | START rejected because of a checksum mismatch |
| opcode_err_o | output | 1 | Unknown command code |
| err_count_o | output | 8 | Saturating count of error strobes |

## Verification
The bench sends every invalid command code and then, without any gap, a valid STOP. A design that failed to return to idle hunting after an error would misframe that STOP or swallow it. A START with a corrupted checksum is checked to leave the previous train number in place, which catches a design that loads the fields before the check completes. A STOP followed immediately by a START tests back-to-back frames, and a wrong bit count in the payload would shift every field. The bench also drives a clear in the same cycle as an error strobe, which exposes an increment that takes priority over the clear, and it pushes the counter past its maximum to catch a count that wraps to zero.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_START = 4'b1100;
  localparam logic [OPC_W-1:0] OPC_STOP  = 4'b1010;
  localparam logic [OPC_W-1:0] OPC_RESET = 4'b1001;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_OPC,
    SEQ_BODY
  } seq_state_t;

  typedef enum logic [1:0] {
    CMD_BAD,
    CMD_START,
    CMD_STOP,
    CMD_RESET
  } cmd_kind_t;

  function automatic cmd_kind_t decode_opc(input logic [OPC_W-1:0] code);
    cmd_kind_t k;
    case (code)
      OPC_START: k = CMD_START;
      OPC_STOP:  k = CMD_STOP;
      OPC_RESET: k = CMD_RESET;
      default:   k = CMD_BAD;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/cmdrx_seq.sv
module cmdrx_seq
  import cmdrx_pkg::*;
#(
  parameter int PAY_W = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  output logic body_en,
  output logic body_last,
  output logic hit_stop,
  output logic hit_reset,
  output logic hit_bad
);

  localparam int CNT_W = $clog2(PAY_W + 1);

  seq_state_t         state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [OPC_W-2:0]   op_q, op_d;
  logic [OPC_W-1:0]   opc_full;
  logic               adv;

  assign opc_full = {op_q, bit_i};
  assign adv      = (state_q != SEQ_IDLE) || bit_i;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    op_d      = {op_q[OPC_W-3:0], bit_i};
    body_en   = 1'b0;
    body_last = 1'b0;
    hit_stop  = 1'b0;
    hit_reset = 1'b0;
    hit_bad   = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (bit_i) begin
          state_d = SEQ_OPC;
          cnt_d   = CNT_W'(1);
        end
      end
      SEQ_OPC: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(OPC_W - 1)) begin
          state_d = SEQ_IDLE;
          case (decode_opc(opc_full))
            CMD_START: begin
              state_d = SEQ_BODY;
              cnt_d   = '0;
            end
            CMD_STOP:  hit_stop  = 1'b1;
            CMD_RESET: hit_reset = 1'b1;
            default:   hit_bad   = 1'b1;
          endcase
        end
      end
      SEQ_BODY: begin
        body_en = 1'b1;
        cnt_d   = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(PAY_W - 1)) begin
          body_last = 1'b1;
          state_d   = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
    end else if (adv) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
    end
  end

endmodule

// File: rtl/cmdrx_payload.sv
module cmdrx_payload #(
  parameter int ID_W  = 32,
  parameter int PAT_W = 8,
  parameter int CS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic             body_en,
  input  logic             body_last,
  output logic [ID_W-1:0]  train_id,
  output logic [PAT_W-1:0] pattern_id,
  output logic             start_stb,
  output logic             csum_err_stb
);

  localparam int PAY_W  = ID_W + PAT_W + CS_W;
  localparam int NCHUNK = (ID_W + PAT_W) / CS_W;

  logic [PAY_W-2:0]            sr_q, sr_d;
  logic [PAY_W-1:0]            frame;
  logic [NCHUNK:0][CS_W-1:0]   fold;
  logic                        sum_ok;
  logic                        load;
  logic [ID_W-1:0]             id_d;
  logic [PAT_W-1:0]            pat_d;
  logic                        start_d, cerr_d;

  assign frame   = {sr_q, bit_i};
  assign fold[0] = '0;

  for (genvar i = 0; i < NCHUNK; i++) begin : g_fold
    assign fold[i+1] = fold[i] ^ frame[CS_W + i*CS_W +: CS_W];
  end

  assign sum_ok = (fold[NCHUNK] == frame[CS_W-1:0]);
  assign load   = body_last && sum_ok;

  always_comb begin
    sr_d    = {sr_q[PAY_W-3:0], bit_i};
    id_d    = frame[PAY_W-1 -: ID_W];
    pat_d   = frame[CS_W +: PAT_W];
    start_d = load;
    cerr_d  = body_last && !sum_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (body_en) begin
      sr_q <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      train_id   <= '0;
      pattern_id <= '0;
    end else if (load) begin
      train_id   <= id_d;
      pattern_id <= pat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_stb    <= 1'b0;
      csum_err_stb <= 1'b0;
    end else begin
      start_stb    <= start_d;
      csum_err_stb <= cerr_d;
    end
  end

endmodule

// File: rtl/cmdrx_errcnt.sv
module cmdrx_errcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] count_d;
  logic         en;

  assign en = inc || clr;

  always_comb begin
    if (clr) begin
      count_d = '0;
    end else if (count != MAXV) begin
      count_d = count + W'(1);
    end else begin
      count_d = count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (en) begin
      count <= count_d;
    end
  end

endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
  parameter int ID_W  = 32,
  parameter int PAT_W = 8,
  parameter int CS_W  = 8,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             err_clr_i,
  output logic             start_o,
  output logic             stop_o,
  output logic             reset_o,
  output logic [ID_W-1:0]  train_id_o,
  output logic [PAT_W-1:0] pattern_id_o,
  output logic             csum_err_o,
  output logic             opcode_err_o,
  output logic [ERR_W-1:0] err_count_o
);

  localparam int PAY_W = ID_W + PAT_W + CS_W;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       body_en, body_last;
  logic       hit_stop, hit_reset, hit_bad;
  logic       stop_q, reset_q, bad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[1];

  cmdrx_seq #(
    .PAY_W (PAY_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bit_i     (line_i),
    .body_en   (body_en),
    .body_last (body_last),
    .hit_stop  (hit_stop),
    .hit_reset (hit_reset),
    .hit_bad   (hit_bad)
  );

  cmdrx_payload #(
    .ID_W  (ID_W),
    .PAT_W (PAT_W),
    .CS_W  (CS_W)
  ) u_payload (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .bit_i        (line_i),
    .body_en      (body_en),
    .body_last    (body_last),
    .train_id     (train_id_o),
    .pattern_id   (pattern_id_o),
    .start_stb    (start_o),
    .csum_err_stb (csum_err_o)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      stop_q  <= 1'b0;
      reset_q <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      stop_q  <= hit_stop;
      reset_q <= hit_reset;
      bad_q   <= hit_bad;
    end
  end

  assign stop_o       = stop_q;
  assign reset_o      = reset_q;
  assign opcode_err_o = bad_q;

  cmdrx_errcnt #(
    .W (ERR_W)
  ) u_errcnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .inc   (csum_err_o || opcode_err_o),
    .clr   (err_clr_i),
    .count (err_count_o)
  );

endmodule

// File: rtl/cmd_frame_rx_chk.sv
module cmd_frame_rx_chk #(
  parameter int ID_W  = 32,
  parameter int PAT_W = 8,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             err_clr_i,
  input logic             start_o,
  input logic             stop_o,
  input logic             reset_o,
  input logic [ID_W-1:0]  train_id_o,
  input logic [PAT_W-1:0] pattern_id_o,
  input logic             csum_err_o,
  input logic             opcode_err_o,
  input logic [ERR_W-1:0] err_count_o
);

  localparam logic [ERR_W-1:0] CMAX = {ERR_W{1'b1}};

  // R12: strobes are exclusive
  assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({start_o, stop_o, reset_o, csum_err_o, opcode_err_o}));

  // R12: strobes last one cycle
  assert_pulse_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start_o || stop_o || reset_o || csum_err_o || opcode_err_o) |=>
    !(start_o || stop_o || reset_o || csum_err_o || opcode_err_o));

  // R5: the train number only changes together with a START strobe
  assert_id_upd_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (train_id_o != $past(train_id_o)) |-> start_o);

  // R7: a rejected frame leaves the fields alone
  assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    csum_err_o |-> ($stable(train_id_o) && $stable(pattern_id_o)));

  // R10: the count holds at its maximum
  assert_sat_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (err_count_o == CMAX && !err_clr_i) |=> (err_count_o == CMAX));

  // R10: an error strobe increments the count
  assert_inc_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((opcode_err_o || csum_err_o) && !err_clr_i && err_count_o != CMAX) |=>
    (err_count_o == ERR_W'($past(err_count_o) + ERR_W'(1))));

  // R11: a clear empties the count
  assert_clr_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    err_clr_i |=> (err_count_o == '0));

endmodule

bind cmd_frame_rx cmd_frame_rx_chk #(
  .ID_W  (ID_W),
  .PAT_W (PAT_W),
  .ERR_W (ERR_W)
) u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .err_clr_i    (err_clr_i),
  .start_o      (start_o),
  .stop_o       (stop_o),
  .reset_o      (reset_o),
  .train_id_o   (train_id_o),
  .pattern_id_o (pattern_id_o),
  .csum_err_o   (csum_err_o),
  .opcode_err_o (opcode_err_o),
  .err_count_o  (err_count_o)
);

// File: tb/tb_cmd_frame_rx.sv
`timescale 1ns/1ps
module tb_cmd_frame_rx;

  logic        clk;
  logic        rst_n;
  logic        line_i;
  logic        err_clr_i;
  logic        start_o, stop_o, reset_o, csum_err_o, opcode_err_o;
  logic [31:0] train_id_o;
  logic [7:0]  pattern_id_o;
  logic [7:0]  err_count_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cmd_frame_rx dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line_i),
    .err_clr_i    (err_clr_i),
    .start_o      (start_o),
    .stop_o       (stop_o),
    .reset_o      (reset_o),
    .train_id_o   (train_id_o),
    .pattern_id_o (pattern_id_o),
    .csum_err_o   (csum_err_o),
    .opcode_err_o (opcode_err_o),
    .err_count_o  (err_count_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] strobes();
    return {start_o, stop_o, reset_o, csum_err_o, opcode_err_o};
  endfunction

  task automatic check_stb(input logic [4:0] exp, input string req);
    check(strobes() == exp, req, 64'(strobes()), 64'(exp));
  endtask

  task automatic drive_bit(input logic b);
    @(negedge clk);
    line_i = b;
    #1;
  endtask

  task automatic send_word(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) drive_bit(v[i]);
  endtask

  function automatic logic [7:0] csum_of(input logic [31:0] id, input logic [7:0] pat);
    return id[31:24] ^ id[23:16] ^ id[15:8] ^ id[7:0] ^ pat;
  endfunction

  task automatic send_start(input logic [31:0] id, input logic [7:0] pat,
                            input logic [7:0] cs);
    send_word(64'b1100, 4);
    send_word(64'(id), 32);
    send_word(64'(pat), 8);
    send_word(64'(cs), 8);
  endtask

  task automatic t_reset;
    check_stb(5'b0, "R1 strobes");
    check(train_id_o == 0, "R1 train id", 64'(train_id_o), 0);
    check(pattern_id_o == 0, "R1 pattern", 64'(pattern_id_o), 0);
    check(err_count_o == 0, "R1 count", 64'(err_count_o), 0);
  endtask

  task automatic t_idle;
    bit quiet = 1;
    for (int i = 0; i < 20; i++) begin
      drive_bit(1'b0);
      if (strobes() != 0) quiet = 0;
    end
    check(quiet, "R2 idle zeros ignored", 64'(quiet), 1);
  endtask

  task automatic t_stop_reset;
    send_word(64'b1010, 4);
    drive_bit(1'b0);
    check_stb(5'b01000, "R3 stop strobe");
    drive_bit(1'b0);
    check_stb(5'b00000, "R3 stop one cycle");
    send_word(64'b1001, 4);
    drive_bit(1'b0);
    check_stb(5'b00100, "R4 reset strobe");
    drive_bit(1'b0);
    check_stb(5'b00000, "R4 reset one cycle");
  endtask

  task automatic t_start(input logic [31:0] id, input logic [7:0] pat, input string tag);
    send_start(id, pat, csum_of(id, pat));
    drive_bit(1'b0);
    check_stb(5'b10000, {tag, " R5 start strobe"});
    check(train_id_o == id, {tag, " R5 R6 train id"}, 64'(train_id_o), 64'(id));
    check(pattern_id_o == pat, {tag, " R5 pattern"}, 64'(pattern_id_o), 64'(pat));
    drive_bit(1'b0);
    check_stb(5'b00000, {tag, " R12 start one cycle"});
  endtask

  task automatic t_bad_csum;
    logic [31:0] id  = 32'hDEAD_BEEF;
    logic [7:0]  pat = 8'h42;
    send_start(id, pat, csum_of(id, pat) ^ 8'h10);
    drive_bit(1'b0);
    check_stb(5'b00010, "R7 csum error strobe");
    check(train_id_o == 32'h0000_0001, "R7 train id kept", 64'(train_id_o), 1);
    check(pattern_id_o == 8'h00, "R7 pattern kept", 64'(pattern_id_o), 0);
    drive_bit(1'b0);
    check(err_count_o == 1, "R10 count after csum error", 64'(err_count_o), 1);
  endtask

  task automatic t_bad_opc;
    logic [3:0] codes [5] = '{4'b1111, 4'b1000, 4'b1011, 4'b1101, 4'b1110};
    for (int k = 0; k < 5; k++) begin
      send_word(64'(codes[k]), 4);
      drive_bit(1'b0);
      check_stb(5'b00001, "R8 opcode error");
    end
    drive_bit(1'b0);
    check(err_count_o == 6, "R10 count after opcode errors", 64'(err_count_o), 6);
    send_word(64'b1111, 4);
    send_word(64'b1010, 4);
    drive_bit(1'b0);
    check_stb(5'b01000, "R8 stop right after bad code");
  endtask

  task automatic t_back2back;
    logic [31:0] id  = 32'h1234_5678;
    logic [7:0]  pat = 8'h9A;
    send_word(64'b1010, 4);
    drive_bit(1'b1);
    check_stb(5'b01000, "R9 first frame strobe");
    send_word(64'b100, 3);
    send_word(64'(id), 32);
    send_word(64'(pat), 8);
    send_word(64'(csum_of(id, pat)), 8);
    drive_bit(1'b0);
    check_stb(5'b10000, "R9 second frame start");
    check(train_id_o == id, "R9 train id", 64'(train_id_o), 64'(id));
  endtask

  task automatic t_clear;
    send_word(64'b1111, 4);
    @(negedge clk);
    line_i = 1'b0;
    err_clr_i = 1'b1;
    #1;
    check_stb(5'b00001, "R11 error with clear");
    @(negedge clk);
    err_clr_i = 1'b0;
    #1;
    check(err_count_o == 0, "R11 clear wins", 64'(err_count_o), 0);
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 260; k++) send_word(64'b1111, 4);
    drive_bit(1'b0);
    drive_bit(1'b0);
    check(err_count_o == 8'hFF, "R10 saturation", 64'(err_count_o), 64'hFF);
  endtask

  initial begin
    rst_n = 1'b0;
    line_i = 1'b0;
    err_clr_i = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_idle();
    t_stop_reset();
    t_start(32'hA5C3_0F81, 8'h3C, "pat A");
    t_start(32'h0000_0001, 8'h00, "pat B");
    t_bad_csum();
    t_bad_opc();
    t_back2back();
    t_clear();
    t_saturate();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule